// File: doc/BRIEF.md
# Memory-Bit Boolean Carry Unit

This unit carries out single-bit boolean instructions. Each one takes one bit of a byte in a 4K-byte memory region and either folds it into the carry flag or changes it in place. The carry flag serves as a one-bit accumulator. The unit can AND, OR or XOR the bit into carry, or load the bit into carry. Each of these four can use the bit or its inverse. The unit can also write carry into the bit, or invert the bit in memory.

The sequencer pulses `start` with a 3-bit operation select, the two operand bytes that follow the opcode, and the present carry. The unit decodes the operands into a 12-bit byte address, a bit position and a complement flag, then issues one read of the byte. The memory is synchronous: read data is valid in the cycle after the read strobe. Bit-modifying operations follow the read with one write of the modified byte. Carry-producing operations present the new carry together with a carry write strobe on the final cycle.

Operation select encoding:

| Code | Operation |
|------|-----------|
| 000 | AND into carry |
| 001 | OR into carry |
| 010 | XOR into carry |
| 011 | load carry |
| 100 | store carry into the bit |
| 101 | invert the bit in memory |
| 110, 111 | unused |

Operand format:

| Field | Bits |
|-------|------|
| Byte address bits 7:0 | low operand byte |
| Byte address bits 11:8 | high operand byte, bits 3:0 |
| Complement flag | high operand byte, bit 4 |
| Bit position | high operand byte, bits 7:5 |

Cycle 1 is the cycle in which `start` is high and accepted.

Top module: `bit_carry_unit`

## Requirements
- R1: When `start` is accepted, the unit latches the byte address {high[3:0], low[7:0]}, the bit position high[7:5] and the complement flag high[4]. It raises `memRdEn` for exactly cycle 2, with `memAddr` equal to the latched address. Addresses 000h to FFFh are all reachable.
- R2: AND (000) gives new carry = carry AND s, where s is the selected bit, inverted when the complement flag is 1. It completes with `done` in cycle 4.
- R3: OR (001) gives new carry = carry OR s, with s defined as in R2. It completes with `done` in cycle 5.
- R4: XOR (010) gives new carry = carry XOR s, with s defined as in R2. It completes with `done` in cycle 5.
- R5: Load carry (011) gives new carry = s, with s defined as in R2. It completes with `done` in cycle 4.
- R6: Store carry (100) drives `memWrEn` for exactly cycle 4. `memWrData` is the byte that was read, with only the selected bit replaced by the carry latched at start. The complement flag is ignored. `done` is asserted in cycle 5.
- R7: Invert (101) drives `memWrEn` for exactly cycle 4. `memWrData` is the byte that was read, with only the selected bit inverted. The complement flag is ignored. `done` is asserted in cycle 5.
- R8: `carryWe` is high only in the `done` cycle of operations 000 to 011, and `carryOut` holds the new carry in that cycle. Operations 100 and 101 never raise `carryWe`.
- R9: `busy` is high from cycle 2 through the `done` cycle. A `start` that arrives while `busy` is high is ignored, together with its operands. A `start` with code 110 or 111 is ignored and causes no memory access.
- R10: While reset is held and after its release, `busy`, `done`, `carryWe`, `memRdEn` and `memWrEn` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| opSel | input | 3 | Operation select (see encoding) |
| operandLo | input | 8 | First operand byte: address bits 7:0 |
| operandHi | input | 8 | Second operand byte: bit position, complement flag, address bits 11:8 |
| carryIn | input | 1 | Present carry flag value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Final cycle of an operation |
| carryOut | output | 1 | New carry value, valid while carryWe is high |
| carryWe | output | 1 | Carry flag update strobe |
| memRdEn | output | 1 | Memory read strobe |
| memWrEn | output | 1 | Memory write strobe |
| memAddr | output | 12 | Memory byte address |
| memWrData | output | 8 | Memory write data |
| memRdData | input | 8 | Memory read data, valid the cycle after memRdEn |

## Verification
The hardest case to reach from the ports is a second `start` that lands while the unit is busy. It matters most when that `start` falls in the very cycle `done` is high, because a careless idle test would accept it and corrupt the next access. The stimulus raises `start`, with a different operation and changed operands, both in the read cycle and in the `done` cycle. It then expects the same read address, write data and carry as an undisturbed run, followed by an idle cycle.

A second hard case is proving that a read-modify-write leaves the other seven bits intact. A store or invert is followed by loads of the same byte, so the bench reads back both the modified bit and its neighbours through the normal carry path.

// File: rtl/bcu_pkg.sv
package bcu_pkg;

  typedef enum logic [2:0] {
    OP_AND  = 3'd0,
    OP_OR   = 3'd1,
    OP_XOR  = 3'd2,
    OP_LDC  = 3'd3,
    OP_STC  = 3'd4,
    OP_NOT  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } bcuOp_e;

  typedef struct packed {
    logic loadOp;    // latch operands and carry
    logic grabByte;  // capture read data
    logic writeByte; // modified byte is on the bus
  } bcuStrobe_t;

  function automatic logic opIsValid(bcuOp_e op);
    return (op != OP_RSV6) && (op != OP_RSV7);
  endfunction

  function automatic logic opIsShort(bcuOp_e op);
    return (op == OP_AND) || (op == OP_LDC);
  endfunction

  function automatic logic opIsRmw(bcuOp_e op);
    return (op == OP_STC) || (op == OP_NOT);
  endfunction

endpackage

// File: rtl/bcu_ctrl.sv
module bcu_ctrl
  import bcu_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  bcuOp_e     opSel,
  output bcuOp_e     opReg,
  output bcuStrobe_t strb,
  output logic       busy,
  output logic       done,
  output logic       memRdEn,
  output logic       memWrEn,
  output logic       carryWe
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CAPTURE,
    ST_MODIFY,
    ST_FINAL
  } state_e;

  state_e state, nextState;
  logic   accept;
  logic   shortOp;
  logic   rmwOp;

  assign accept  = start && (state == ST_IDLE) && opIsValid(opSel);
  assign shortOp = opIsShort(opReg);
  assign rmwOp   = opIsRmw(opReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      opReg <= OP_AND;
    end else begin
      state <= nextState;
      if (accept) opReg <= opSel;
    end
  end

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE:    if (accept) nextState = ST_READ;
      ST_READ:    nextState = ST_CAPTURE;
      ST_CAPTURE: nextState = ST_MODIFY;
      ST_MODIFY:  nextState = shortOp ? ST_IDLE : ST_FINAL;
      ST_FINAL:   nextState = ST_IDLE;
      default:    nextState = ST_IDLE;
    endcase
  end

  assign busy    = (state != ST_IDLE);
  assign memRdEn = (state == ST_READ);
  assign memWrEn = (state == ST_MODIFY) && rmwOp;
  assign done    = ((state == ST_MODIFY) && shortOp) || (state == ST_FINAL);
  assign carryWe = done && !rmwOp;

  assign strb.loadOp    = accept;
  assign strb.grabByte  = (state == ST_CAPTURE);
  assign strb.writeByte = memWrEn;

  // R1: an accepted start leads to exactly one read, in the next cycle
  assert_read_follows_accept_R1: assert property (@(posedge clk) disable iff (!rstN)
    accept |=> memRdEn);
  assert_single_read_R1: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> (!memRdEn && busy));
  // R6 / R7: write strobe lasts one cycle and the operation ends right after
  assert_single_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |=> (!memWrEn && done));
  // R8: no carry update during a read-modify-write
  assert_no_carry_on_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> !carryWe);
  // R9: done is the last busy cycle
  assert_done_ends_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);
  assert_done_when_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

endmodule

// File: rtl/bcu_datapath.sv
module bcu_datapath
  import bcu_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  bcuStrobe_t        strb,
  input  bcuOp_e            opReg,
  input  logic [DATA_W-1:0] operandLo,
  input  logic [DATA_W-1:0] operandHi,
  input  logic              carryIn,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              carryOut
);

  localparam int POS_W   = $clog2(DATA_W);
  localparam int HI_W    = ADDR_W - DATA_W;
  localparam int CPL_BIT = HI_W;
  localparam int POS_LSB = HI_W + 1;

  logic [ADDR_W-1:0] addrReg;
  logic [POS_W-1:0]  posReg;
  logic              cplReg;
  logic              carryReg;
  logic [DATA_W-1:0] byteReg;
  logic              selBit;
  logic              srcBit;
  logic              replBit;
  logic              newCarry;
  logic [DATA_W-1:0] wrData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg  <= '0;
      posReg   <= '0;
      cplReg   <= 1'b0;
      carryReg <= 1'b0;
      byteReg  <= '0;
    end else begin
      if (strb.loadOp) begin
        addrReg  <= {operandHi[HI_W-1:0], operandLo};
        cplReg   <= operandHi[CPL_BIT];
        posReg   <= operandHi[POS_LSB +: POS_W];
        carryReg <= carryIn;
      end
      if (strb.grabByte) byteReg <= memRdData;
    end
  end

  assign selBit  = byteReg[posReg];
  assign srcBit  = cplReg ? ~selBit : selBit;
  assign replBit = (opReg == OP_STC) ? carryReg : ~selBit;

  always_comb begin
    case (opReg)
      OP_AND:  newCarry = carryReg & srcBit;
      OP_OR:   newCarry = carryReg | srcBit;
      OP_XOR:  newCarry = carryReg ^ srcBit;
      OP_LDC:  newCarry = srcBit;
      default: newCarry = carryReg;
    endcase
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign wrData[i] = (posReg == POS_W'(i)) ? replBit : byteReg[i];
  end

  assign memAddr   = addrReg;
  assign memWrData = wrData;
  assign carryOut  = newCarry;

  // R6 / R7: a written byte differs from the read byte in at most one bit
  assert_one_bit_changes_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.writeByte |-> ($countones(wrData ^ byteReg) <= 1));
  // R1: address holds steady while the byte is being fetched
  assert_addr_stable_R1: assert property (@(posedge clk) disable iff (!rstN)
    strb.grabByte |-> $stable(addrReg));

endmodule

// File: rtl/bit_carry_unit.sv
module bit_carry_unit
  import bcu_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        opSel,
  input  logic [DATA_W-1:0] operandLo,
  input  logic [DATA_W-1:0] operandHi,
  input  logic              carryIn,
  output logic              busy,
  output logic              done,
  output logic              carryOut,
  output logic              carryWe,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData
);

  bcuStrobe_t strb;
  bcuOp_e     opReg;

  bcu_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .opSel   (bcuOp_e'(opSel)),
    .opReg   (opReg),
    .strb    (strb),
    .busy    (busy),
    .done    (done),
    .memRdEn (memRdEn),
    .memWrEn (memWrEn),
    .carryWe (carryWe)
  );

  bcu_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .opReg     (opReg),
    .operandLo (operandLo),
    .operandHi (operandHi),
    .carryIn   (carryIn),
    .memRdData (memRdData),
    .memAddr   (memAddr),
    .memWrData (memWrData),
    .carryOut  (carryOut)
  );

endmodule

// File: tb/sim_bit_carry_unit.sv
module sim_bit_carry_unit;

  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic [2:0]  opSel;
  logic [7:0]  operandLo;
  logic [7:0]  operandHi;
  logic        carryIn;
  logic        busy, done, carryOut, carryWe, memRdEn, memWrEn;
  logic [11:0] memAddr;
  logic [7:0]  memWrData;
  logic [7:0]  memRdData;

  int checks = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bit_carry_unit u0 (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
    .operandLo(operandLo), .operandHi(operandHi), .carryIn(carryIn),
    .busy(busy), .done(done), .carryOut(carryOut), .carryWe(carryWe),
    .memRdEn(memRdEn), .memWrEn(memWrEn), .memAddr(memAddr),
    .memWrData(memWrData), .memRdData(memRdData)
  );

  // behavioural memory: computed initial contents plus recorded writes
  logic [7:0] written [int];

  function automatic logic [7:0] memRead(logic [11:0] a);
    if (written.exists(int'(a))) return written[int'(a)];
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (memRdEn) memRdData <= memRead(memAddr);
    if (memWrEn) written[int'(memAddr)] = memWrData;
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Runs one operation and compares every cycle against the reference timeline.
  task automatic runOp(input logic [2:0] op, input logic [11:0] addr,
                       input logic [2:0] pos, input logic cpl, input logic cin,
                       input string tag, input bit probe);
    logic [7:0] orig, expW;
    logic       bitv, s, expC, rmw;
    int         nTot;
    logic [4:0] expCtl, actCtl;
    orig = memRead(addr);
    bitv = orig[pos];
    s    = bitv ^ cpl;
    rmw  = (op == 3'd4) || (op == 3'd5);
    nTot = (op == 3'd0 || op == 3'd3) ? 4 : 5;
    case (op)
      3'd0: expC = cin & s;
      3'd1: expC = cin | s;
      3'd2: expC = cin ^ s;
      3'd3: expC = s;
      default: expC = cin;
    endcase
    expW = orig;
    if (op == 3'd4) expW[pos] = cin;
    if (op == 3'd5) expW[pos] = ~bitv;

    @(negedge clk);
    start = 1'b1; opSel = op; carryIn = cin;
    operandLo = addr[7:0];
    operandHi = {pos, cpl, addr[11:8]};
    for (int j = 1; j <= nTot; j++) begin
      @(negedge clk);
      expCtl = {(j < nTot), (j == nTot - 1), (j == 1), (rmw && j == 3),
                ((j == nTot - 1) && !rmw)};
      actCtl = {busy, done, memRdEn, memWrEn, carryWe};
      check(actCtl == expCtl, {tag, "/R8/R9"}, $sformatf("ctl cycle %0d", j + 1),
            32'(actCtl), 32'(expCtl));
      if (j == 1)
        check(memAddr == addr, "R1", "read address", 32'(memAddr), 32'(addr));
      if (rmw && j == 3) begin
        check(memWrData == expW, tag, "write data", 32'(memWrData), 32'(expW));
        check(memAddr == addr, tag, "write address", 32'(memAddr), 32'(addr));
      end
      if (!rmw && j == nTot - 1)
        check(carryOut == expC, tag, "carry", 32'(carryOut), 32'(expC));
      start = probe && (j == 1 || j == nTot - 1);
      if (start) begin
        opSel = 3'd0; carryIn = ~cin;
        operandLo = ~addr[7:0]; operandHi = ~{pos, cpl, addr[11:8]};
      end
    end
    start = 1'b0;
  endtask

  task automatic ignoredOp(input logic [2:0] op);
    @(negedge clk);
    start = 1'b1; opSel = op; operandLo = 8'h11; operandHi = 8'h02;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 2; k++) begin
      check({busy, done, memRdEn, memWrEn, carryWe} == 5'b0, "R9",
            "unused code ignored", 32'({busy, done, memRdEn, memWrEn, carryWe}), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      bad++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; start = 1'b0; opSel = 3'd0;
    operandLo = 8'h00; operandHi = 8'h00; carryIn = 1'b0;
    repeat (3) @(negedge clk);
    check({busy, done, memRdEn, memWrEn, carryWe} == 5'b0, "R10", "in reset",
          32'({busy, done, memRdEn, memWrEn, carryWe}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check({busy, done, memRdEn, memWrEn, carryWe} == 5'b0, "R10", "after reset",
          32'({busy, done, memRdEn, memWrEn, carryWe}), 0);

    // AND into carry, plain and complemented, address extremes
    runOp(3'd0, 12'h000, 3'd0, 1'b0, 1'b1, "R2", 0);
    runOp(3'd0, 12'hFFF, 3'd7, 1'b1, 1'b1, "R2", 0);
    runOp(3'd0, 12'h135, 3'd2, 1'b0, 1'b0, "R2", 0);
    // OR into carry
    runOp(3'd1, 12'h7A0, 3'd3, 1'b0, 1'b0, "R3", 0);
    runOp(3'd1, 12'h7A0, 3'd3, 1'b1, 1'b0, "R3", 0);
    // XOR into carry
    runOp(3'd2, 12'h2EE, 3'd1, 1'b0, 1'b1, "R4", 0);
    runOp(3'd2, 12'h2EE, 3'd6, 1'b1, 1'b1, "R4", 0);
    // load carry, plain and inverted
    runOp(3'd3, 12'h0C0, 3'd2, 1'b0, 1'b0, "R5", 0);
    runOp(3'd3, 12'h0C0, 3'd2, 1'b1, 1'b1, "R5", 0);
    // store carry with complement flag set (ignored), then read back
    runOp(3'd4, 12'h046, 3'd3, 1'b1, 1'b1, "R6", 0);
    runOp(3'd3, 12'h046, 3'd3, 1'b0, 1'b0, "R6", 0);
    runOp(3'd3, 12'h046, 3'd4, 1'b0, 1'b0, "R6", 0);
    runOp(3'd4, 12'hFFF, 3'd0, 1'b0, 1'b0, "R6", 0);
    runOp(3'd3, 12'hFFF, 3'd0, 1'b0, 1'b1, "R6", 0);
    // invert bit in memory, then read back
    runOp(3'd5, 12'h046, 3'd3, 1'b1, 1'b1, "R7", 0);
    runOp(3'd3, 12'h046, 3'd3, 1'b0, 1'b1, "R7", 0);
    runOp(3'd5, 12'h000, 3'd7, 1'b0, 1'b0, "R7", 0);
    runOp(3'd3, 12'h000, 3'd6, 1'b0, 1'b1, "R7", 0);
    // start while busy, including in the done cycle
    runOp(3'd2, 12'h3C5, 3'd5, 1'b0, 1'b1, "R9", 1);
    runOp(3'd5, 12'h3C5, 3'd5, 1'b0, 1'b0, "R9", 1);
    runOp(3'd0, 12'h3C5, 3'd5, 1'b1, 1'b1, "R9", 1);
    // unused codes
    ignoredOp(3'd6);
    ignoredOp(3'd7);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

endmodule